// File: doc/BRIEF.md
# Hash Offload Register Front End

This block is the software-visible control face of a hash offload engine. A host on a simple 32-bit write/read bus programs a source address, a digest destination address and a byte count, then writes a hash command word. That command write both selects the algorithm and launches the job. The block hands the stored parameters and a one-cycle start strobe to a downstream hash datapath, which answers with a done strobe when it finishes.

While a job runs, the block shows a busy bit. When the job finishes it sets a sticky completion flag and raises its interrupt output. Software clears the flag by writing 1 to that flag's bit. Stored addresses and lengths are trimmed to the widths the engine can reach, and the digest address is always kept on an 8-byte boundary.

Top module: `hash_reg_front`

## Requirements
- R1: After reset, every register (0x10, 0x20, 0x24, 0x2C, 0x30) reads zero, status (0x1C) reads zero, irq is low and the start strobe is low.
- R2: A write to the source address register (0x20) keeps bits 30:0, so writing all ones reads back 0x7FFFFFFF.
- R3: A write to the digest address register (0x24) keeps bits 30:3, so writing all ones reads back 0x7FFFFFF8.
- R4: A write to the length register (0x2C) keeps bits 27:0, so writing all ones reads back 0x0FFFFFFF.
- R5: The general command register (0x10) stores and reads back all 32 bits. Offset 0x28 (key buffer, out of scope) and any other unmapped offset read zero, and writes to them are ignored.
- R6: While the engine is idle, a hash command write (0x30) with a valid algorithm code is handled as follows:
  - The command is latched. It reads back masked to 0x0004047C.
  - startPulse is high for exactly the one cycle after the write.
  - jobSrc, jobDst and jobLen carry the stored register values.
  - Status bit 0 (busy) reads 1.
- R7: The algorithm code is formed from command bits {10,6,5,4}. It maps to jobAlgo as follows:
  - 0000 maps to 0 (MD5).
  - 0010 maps to 1 (SHA1).
  - 0100 maps to 2 (SHA224).
  - 0101 maps to 3 (SHA256).
  - 1110 maps to 4 (SHA384).
  - 0110 maps to 5 (SHA512).
- R8: For the latched command:
  - jobShaBigEnd follows command bit 3.
  - jobMd5LittleEnd follows command bit 2.
  - jobScatter follows command bit 18.
- R9: A hash command write while busy is ignored: no start strobe is issued and the command readback is unchanged.
- R10: A hash command write with any other algorithm code is ignored: no start strobe, no busy, and the command readback is unchanged.
- R11: When hashDone is high while busy, busy clears and status bit 9 sets at the same edge. Status then reads exactly 0x00000200 and irq is high. hashDone while idle has no effect.
- R12: A status write clears bit 9 only where the written data has bit 9 set. Writing 0 has no effect. Busy cannot be written, and unimplemented status bits read zero. Status reads zero after the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busAddr | input | ADDR_W | Byte offset for read and write |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr (combinational) |
| hashDone | input | 1 | Datapath finished the current job |
| startPulse | output | 1 | One-cycle job launch strobe |
| jobSrc | output | 32 | Stored source address |
| jobDst | output | 32 | Stored digest address |
| jobLen | output | 32 | Stored data length |
| jobAlgo | output | 3 | Decoded algorithm code |
| jobShaBigEnd | output | 1 | Big-endian SHA output enable |
| jobMd5LittleEnd | output | 1 | Little-endian MD5 output enable |
| jobScatter | output | 1 | Scatter-gather source enable |
| irq | output | 1 | OR of the interrupt flags |

## Verification
The bench targets several corner cases, each paired with the fault it exposes:
- It writes all ones to each address register and compares the readback. A missing or shifted mask shows up as extra high bits, or as a digest address that is not 8-byte aligned.
- It sends invalid algorithm codes and reissues commands while busy. A design that starts anyway pulses startPulse or changes the command readback.
- It writes zero, and every bit except bit 9, to a set flag. It also pulses done while idle. A design that treats the status register as plain storage would lose the flag, set busy, or raise a spurious interrupt.

// File: rtl/hreg_pkg.sv
package hreg_pkg;

  typedef enum logic [2:0] {
    ALG_MD5    = 3'd0,
    ALG_SHA1   = 3'd1,
    ALG_SHA224 = 3'd2,
    ALG_SHA256 = 3'd3,
    ALG_SHA384 = 3'd4,
    ALG_SHA512 = 3'd5
  } hashAlgo_t;

  // write strobes from control to the register datapath
  typedef struct packed {
    logic wrSrc;
    logic wrDst;
    logic wrLen;
    logic wrGen;
    logic wrCmd;
  } regStrobe_t;

  // status bit positions
  localparam int STS_HASH_BUSY = 0;
  localparam int STS_CRYP_BUSY = 1;
  localparam int STS_RSA_BUSY  = 2;
  localparam int STS_HASH_FLAG = 9;
  localparam int STS_CRYP_FLAG = 12;
  localparam int STS_RSA_FLAG  = 13;

  // command bit positions
  localparam int CMD_MD5_LE  = 2;
  localparam int CMD_SHA_BE  = 3;
  localparam int CMD_SCATTER = 18;

  function automatic logic [3:0] algoKey(input logic [31:0] cmd);
    return {cmd[10], cmd[6], cmd[5], cmd[4]};
  endfunction

  function automatic logic algoValid(input logic [31:0] cmd);
    case (algoKey(cmd))
      4'b0000, 4'b0010, 4'b0100, 4'b0101, 4'b0110, 4'b1110: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic hashAlgo_t algoCode(input logic [31:0] cmd);
    case (algoKey(cmd))
      4'b0010: return ALG_SHA1;
      4'b0100: return ALG_SHA224;
      4'b0101: return ALG_SHA256;
      4'b1110: return ALG_SHA384;
      4'b0110: return ALG_SHA512;
      default: return ALG_MD5;
    endcase
  endfunction

endpackage

// File: rtl/hreg_datapath.sv
module hreg_datapath
  import hreg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter logic [DATA_W-1:0] SRC_MASK = 32'h7FFF_FFFF,
  parameter logic [DATA_W-1:0] DST_MASK = 32'h7FFF_FFF8,
  parameter logic [DATA_W-1:0] LEN_MASK = 32'h0FFF_FFFF,
  parameter logic [DATA_W-1:0] CMD_MASK = 32'h0004_047C,
  parameter logic [ADDR_W-1:0] GEN_OFF = 'h10,
  parameter logic [ADDR_W-1:0] STS_OFF = 'h1C,
  parameter logic [ADDR_W-1:0] SRC_OFF = 'h20,
  parameter logic [ADDR_W-1:0] DST_OFF = 'h24,
  parameter logic [ADDR_W-1:0] LEN_OFF = 'h2C,
  parameter logic [ADDR_W-1:0] CMD_OFF = 'h30
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] statusWord,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] srcReg,
  output logic [DATA_W-1:0] dstReg,
  output logic [DATA_W-1:0] lenReg,
  output hashAlgo_t         algo,
  output logic              shaBigEnd,
  output logic              md5LittleEnd,
  output logic              scatter
);

  logic [DATA_W-1:0] genReg;
  logic [DATA_W-1:0] cmdReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcReg <= '0;
      dstReg <= '0;
      lenReg <= '0;
      genReg <= '0;
      cmdReg <= '0;
    end else begin
      if (strobe.wrSrc) srcReg <= wrData & SRC_MASK;
      if (strobe.wrDst) dstReg <= wrData & DST_MASK;
      if (strobe.wrLen) lenReg <= wrData & LEN_MASK;
      if (strobe.wrGen) genReg <= wrData;
      if (strobe.wrCmd) cmdReg <= wrData & CMD_MASK;
    end
  end

  always_comb begin
    algo         = algoCode(cmdReg);
    shaBigEnd    = cmdReg[CMD_SHA_BE];
    md5LittleEnd = cmdReg[CMD_MD5_LE];
    scatter      = cmdReg[CMD_SCATTER];
  end

  always_comb begin
    rdData = '0;
    if (rdAddr == GEN_OFF) rdData = genReg;
    if (rdAddr == STS_OFF) rdData = statusWord;
    if (rdAddr == SRC_OFF) rdData = srcReg;
    if (rdAddr == DST_OFF) rdData = dstReg;
    if (rdAddr == LEN_OFF) rdData = lenReg;
    if (rdAddr == CMD_OFF) rdData = cmdReg;
  end

  // R3: digest address is never stored unaligned
  a_r3_dst_aligned: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrDst |=> (dstReg[2:0] == 3'b000));

endmodule

// File: rtl/hreg_control.sv
module hreg_control
  import hreg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] GEN_OFF = 'h10,
  parameter logic [ADDR_W-1:0] STS_OFF = 'h1C,
  parameter logic [ADDR_W-1:0] SRC_OFF = 'h20,
  parameter logic [ADDR_W-1:0] DST_OFF = 'h24,
  parameter logic [ADDR_W-1:0] LEN_OFF = 'h2C,
  parameter logic [ADDR_W-1:0] CMD_OFF = 'h30
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              hashDone,
  output regStrobe_t        strobe,
  output logic              startPulse,
  output logic [DATA_W-1:0] statusWord,
  output logic              irq
);

  logic hashBusy;
  logic hashFlag;
  logic stsWr;
  logic cmdWr;
  logic doneTake;
  // the crypto and RSA engines lie outside this block
  logic crypBusy, rsaBusy, crypFlag, rsaFlag;

  assign crypBusy = 1'b0;
  assign rsaBusy  = 1'b0;
  assign crypFlag = 1'b0;
  assign rsaFlag  = 1'b0;

  assign stsWr    = busWrEn && (busAddr == STS_OFF);
  assign cmdWr    = busWrEn && (busAddr == CMD_OFF);
  assign doneTake = hashDone && hashBusy;

  always_comb begin
    strobe       = '0;
    strobe.wrSrc = busWrEn && (busAddr == SRC_OFF);
    strobe.wrDst = busWrEn && (busAddr == DST_OFF);
    strobe.wrLen = busWrEn && (busAddr == LEN_OFF);
    strobe.wrGen = busWrEn && (busAddr == GEN_OFF);
    strobe.wrCmd = cmdWr && !hashBusy && algoValid(busWrData);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hashBusy   <= 1'b0;
      hashFlag   <= 1'b0;
      startPulse <= 1'b0;
    end else begin
      startPulse <= strobe.wrCmd;
      if (strobe.wrCmd)  hashBusy <= 1'b1;
      else if (doneTake) hashBusy <= 1'b0;
      if (doneTake) hashFlag <= 1'b1;
      else if (stsWr && busWrData[STS_HASH_FLAG]) hashFlag <= 1'b0;
    end
  end

  always_comb begin
    statusWord                = '0;
    statusWord[STS_HASH_BUSY] = hashBusy;
    statusWord[STS_CRYP_BUSY] = crypBusy;
    statusWord[STS_RSA_BUSY]  = rsaBusy;
    statusWord[STS_HASH_FLAG] = hashFlag;
    statusWord[STS_CRYP_FLAG] = crypFlag;
    statusWord[STS_RSA_FLAG]  = rsaFlag;
    irq = hashFlag | crypFlag | rsaFlag;
  end

  // R6: start lasts one cycle and coincides with busy
  a_r6_start_single: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> !startPulse);
  a_r6_start_busy: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |-> hashBusy);
  // R9: command while busy never launches
  a_r9_busy_ignores_cmd: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && hashBusy) |=> !startPulse);
  // R11: done ends the job and raises the flag at one edge
  a_r11_done_flags: assert property (@(posedge clk) disable iff (!rstN)
    doneTake |=> (hashFlag && !hashBusy));
  a_r11_flag_origin: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hashFlag) |-> $past(doneTake));
  // R12: write-one clears the flag
  a_r12_w1c: assert property (@(posedge clk) disable iff (!rstN)
    (stsWr && busWrData[STS_HASH_FLAG] && !doneTake) |=> !hashFlag);

endmodule

// File: rtl/hash_reg_front.sv
module hash_reg_front
  import hreg_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  input  logic              hashDone,
  output logic              startPulse,
  output logic [31:0]       jobSrc,
  output logic [31:0]       jobDst,
  output logic [31:0]       jobLen,
  output logic [2:0]        jobAlgo,
  output logic              jobShaBigEnd,
  output logic              jobMd5LittleEnd,
  output logic              jobScatter,
  output logic              irq
);

  localparam int DATA_W = 32;

  regStrobe_t        strobe;
  logic [DATA_W-1:0] statusWord;
  hashAlgo_t         algo;

  hreg_control #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .hashDone(hashDone), .strobe(strobe),
    .startPulse(startPulse), .statusWord(statusWord), .irq(irq)
  );

  hreg_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(busWrData),
    .rdAddr(busAddr), .statusWord(statusWord), .rdData(busRdData),
    .srcReg(jobSrc), .dstReg(jobDst), .lenReg(jobLen), .algo(algo),
    .shaBigEnd(jobShaBigEnd), .md5LittleEnd(jobMd5LittleEnd),
    .scatter(jobScatter)
  );

  assign jobAlgo = algo;

endmodule

// File: tb/sim_hash_reg_front.sv
module sim_hash_reg_front;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        hashDone = 1'b0;
  logic        startPulse;
  logic [31:0] jobSrc, jobDst, jobLen;
  logic [2:0]  jobAlgo;
  logic        jobShaBigEnd, jobMd5LittleEnd, jobScatter, irq;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  hash_reg_front u0 (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .hashDone(hashDone),
    .startPulse(startPulse), .jobSrc(jobSrc), .jobDst(jobDst),
    .jobLen(jobLen), .jobAlgo(jobAlgo), .jobShaBigEnd(jobShaBigEnd),
    .jobMd5LittleEnd(jobMd5LittleEnd), .jobScatter(jobScatter), .irq(irq)
  );

  typedef struct packed {
    logic [31:0] cmd;
    logic [2:0]  algo;
    logic        ok;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0008, 3'd0, 1'b1},
    '{32'h0000_0024, 3'd1, 1'b1},
    '{32'h0000_0040, 3'd2, 1'b1},
    '{32'h0004_0058, 3'd3, 1'b1},
    '{32'h0000_0460, 3'd4, 1'b1},
    '{32'h8000_0060, 3'd5, 1'b1},
    '{32'h0000_0030, 3'd0, 1'b0},
    '{32'h0000_0400, 3'd0, 1'b0},
    '{32'h0000_0470, 3'd0, 1'b0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdData;
  endtask

  task automatic finishJob();
    @(negedge clk); hashDone = 1'b1;
    @(negedge clk); hashDone = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [31:0] expCmd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(8'h10, v); check("R1 gen", v, 0);
    rd(8'h1C, v); check("R1 status", v, 0);
    rd(8'h20, v); check("R1 src", v, 0);
    rd(8'h24, v); check("R1 dst", v, 0);
    rd(8'h2C, v); check("R1 len", v, 0);
    rd(8'h30, v); check("R1 cmd", v, 0);
    check("R1 irq", {31'b0, irq}, 0);
    check("R1 start", {31'b0, startPulse}, 0);

    // R2 R3 R4 masks
    wr(8'h20, 32'hFFFF_FFFF); rd(8'h20, v); check("R2 src mask", v, 32'h7FFF_FFFF);
    wr(8'h24, 32'hFFFF_FFFF); rd(8'h24, v); check("R3 dst mask", v, 32'h7FFF_FFF8);
    wr(8'h2C, 32'hFFFF_FFFF); rd(8'h2C, v); check("R4 len mask", v, 32'h0FFF_FFFF);

    // R5 general register and unmapped offsets
    wr(8'h10, 32'hDEAD_BEEF); rd(8'h10, v); check("R5 gen", v, 32'hDEAD_BEEF);
    wr(8'h28, 32'hFFFF_FFFF); rd(8'h28, v); check("R5 key buf", v, 0);
    rd(8'h10, v); check("R5 gen after key write", v, 32'hDEAD_BEEF);

    wr(8'h20, 32'h1234_5678);
    wr(8'h24, 32'h8765_4321);
    wr(8'h2C, 32'hF000_0123);

    // R6 R7 R8 R10 vector table
    expCmd = 32'h0;
    for (int i = 0; i < NV; i++) begin
      wr(8'h30, VECS[i].cmd);
      if (VECS[i].ok) begin
        expCmd = VECS[i].cmd & 32'h0004_047C;
        check("R6 start", {31'b0, startPulse}, 1);
        check("R6 src", jobSrc, 32'h1234_5678);
        check("R6 dst", jobDst, 32'h0765_4320);
        check("R6 len", jobLen, 32'h0000_0123);
        check("R7 algo", {29'b0, jobAlgo}, {29'b0, VECS[i].algo});
        check("R8 opts", {29'b0, jobScatter, jobShaBigEnd, jobMd5LittleEnd},
              {29'b0, VECS[i].cmd[18], VECS[i].cmd[3], VECS[i].cmd[2]});
        rd(8'h30, v); check("R6 cmd readback", v, expCmd);
        rd(8'h1C, v); check("R6 busy", v, 32'h1);
        @(negedge clk);
        check("R6 start one cycle", {31'b0, startPulse}, 0);
        finishJob();
        rd(8'h1C, v); check("R11 status done", v, 32'h200);
        check("R11 irq", {31'b0, irq}, 1);
        wr(8'h1C, 32'h200);
        rd(8'h1C, v); check("R12 cleared", v, 0);
        check("R12 irq low", {31'b0, irq}, 0);
      end else begin
        check("R10 no start", {31'b0, startPulse}, 0);
        rd(8'h1C, v); check("R10 not busy", v, 0);
        rd(8'h30, v); check("R10 cmd kept", v, expCmd);
      end
    end

    // R9 command while busy
    wr(8'h30, 32'h0000_0050);
    wr(8'h30, 32'h0000_0060);
    check("R9 no start", {31'b0, startPulse}, 0);
    rd(8'h30, v); check("R9 cmd kept", v, 32'h50);
    check("R9 algo", {29'b0, jobAlgo}, 3);
    rd(8'h1C, v); check("R9 still busy", v, 32'h1);
    finishJob();

    // R12 zero writes and unimplemented bits leave the flag
    wr(8'h1C, 32'h0);
    rd(8'h1C, v); check("R12 write zero", v, 32'h200);
    wr(8'h1C, 32'hFFFF_FDFF);
    rd(8'h1C, v); check("R12 other bits", v, 32'h200);
    wr(8'h1C, 32'h200);
    rd(8'h1C, v); check("R12 clear", v, 0);
    wr(8'h1C, 32'h1);
    rd(8'h1C, v); check("R12 busy read-only", v, 0);

    // R11 done while idle
    finishJob();
    rd(8'h1C, v); check("R11 idle done", v, 0);
    check("R11 idle irq", {31'b0, irq}, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule